// File: doc/BRIEF.md
# Interrupt Priority and Acceptance Unit

This block keeps the pending, in-service and trigger-type state for 256 interrupt vectors. It decides whether the highest waiting vector may interrupt the processor and answers the processor's acknowledge cycle. Vectors come in on a set port together with their trigger type. Software supplies a task priority and a spurious-vector/enable register.

The block derives a processor priority from two things: the task priority and the highest vector currently in service. A waiting vector interrupts only when its 16-vector priority class is above that priority. An acknowledge that arrives while the waiting vector is masked returns the spurious vector and changes no state.

An end-of-interrupt retires the highest in-service vector. If that vector was level-triggered, the block emits a one-cycle broadcast carrying the vector number.

Top module: `irq_prio_unit`

## Requirements
- R1: Every vector 0..255 owns its own request, in-service and trigger-type bit, held as eight 32-bit words per array. Vectors on either side of a word boundary (for example 31 and 32) resolve independently.
- R2: Within an array, the highest-numbered set bit has the highest priority. An empty array reports no vector.
- R3: `ppr_o` follows from the task priority and the in-service class, where a class is bits [7:4] of a vector and an empty in-service array counts as class 0. When the task-priority class is greater than or equal to the in-service class, `ppr_o` equals the task priority. Otherwise it is the in-service class in bits [7:4] with bits [3:0] zero.
- R4: `irq_o` can be high only when bit 8 (enable) of the spurious-vector register is 1 and at least one request bit is set.
- R5: A request is masked when `ppr_o` is nonzero and the class of the highest request is less than or equal to `ppr_o[7:4]`. A masked request keeps `irq_o` low.
- R6: An acknowledge of a deliverable vector clears its request bit and sets its in-service bit. One cycle later it shows the vector on `ack_vec_o` with `ack_valid_o` high for one cycle.
- R7: An acknowledge while the highest request is masked returns the spurious-vector register bits [7:0] and leaves all arrays unchanged. An acknowledge with no request, or with enable clear, produces no `ack_valid_o`.
- R8: A set strobe sets the vector's request bit. It sets the trigger bit when `set_level_i` is 1 (level) and clears it when `set_level_i` is 0 (edge).
- R9: An end-of-interrupt clears the highest in-service bit. One cycle later it pulses `eoi_bcast_o` with `eoi_vec_o` only if that vector's trigger bit is set. With the in-service array empty it does nothing.
- R10: The spurious-vector register holds 9 bits and the task priority holds 8 bits. `irq_o` and `ppr_o` reflect a write from the cycle after it.
- R11: When a set and an acknowledge arrive in the same cycle, the set is applied first, so the newly set vector competes in that acknowledge.
- R12: After reset, the task priority is 0, the spurious-vector register is 0x0FF (disabled), all arrays are empty, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_valid_i | input | 1 | Set-vector strobe |
| set_vec_i | input | 8 | Vector to set |
| set_level_i | input | 1 | 1 = level-triggered, 0 = edge |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 8 | Task-priority value |
| svr_we_i | input | 1 | Spurious-vector register write strobe |
| svr_wdata_i | input | 9 | Bit 8 enable, bits [7:0] spurious vector |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| ppr_o | output | 8 | Processor priority |
| ack_valid_o | output | 1 | Acknowledge result valid (one cycle) |
| ack_vec_o | output | 8 | Acknowledged or spurious vector |
| eoi_bcast_o | output | 1 | Level-triggered EOI broadcast pulse |
| eoi_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
A wrong request bit appears at once on `irq_o`. It also appears in the vector returned by the next acknowledge. A wrong in-service bit appears on `ppr_o` in the very next cycle and in the masking decision, so every step compares both outputs against an independent model. A wrong trigger bit stays hidden until that vector is retired, so directed sequences set, acknowledge and retire both level and edge vectors and check the broadcast one cycle after each EOI.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned CLASS_W = 4;
  localparam logic [8:0]  SVR_RST = 9'h0FF;

  typedef enum logic [1:0] {
    ACK_NONE  = 2'd0,
    ACK_TAKE  = 2'd1,
    ACK_SPUR  = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/irq_prio_find.sv
// Highest set bit: pick highest non-empty word, then highest bit in it.
module irq_prio_find #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS),
  localparam int unsigned BSEL_W   = $clog2(WORD_W),
  localparam int unsigned IDX_W    = WSEL_W + BSEL_W
) (
  input  logic [NUM_WORDS*WORD_W-1:0] bits_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [NUM_WORDS-1:0] word_nz;
  logic [WSEL_W-1:0]    wsel;
  logic [BSEL_W-1:0]    bsel;
  logic [WORD_W-1:0]    word_sel;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_nz
    assign word_nz[w] = |bits_i[w*WORD_W +: WORD_W];
  end

  always_comb begin
    wsel = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_nz[w]) wsel = WSEL_W'(w);
    end
  end

  assign word_sel = bits_i[wsel*WORD_W +: WORD_W];

  always_comb begin
    bsel = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (word_sel[b]) bsel = BSEL_W'(b);
    end
  end

  assign any_o = |word_nz;
  assign idx_o = {wsel, bsel};
endmodule

// File: rtl/irq_vec_bank.sv
// One vector bit array held as words; SET_WINS picks the set/clear priority.
module irq_vec_bank #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 32,
  parameter bit          SET_WINS  = 1'b1,
  localparam int unsigned NUM_BITS = NUM_WORDS * WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_BITS-1:0] set_mask_i,
  input  logic [NUM_BITS-1:0] clr_mask_i,
  output logic [NUM_BITS-1:0] bits_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] s_w;
    logic [WORD_W-1:0] c_w;

    assign s_w = set_mask_i[w*WORD_W +: WORD_W];
    assign c_w = clr_mask_i[w*WORD_W +: WORD_W];

    if (SET_WINS) begin : g_set_wins
      assign word_d = (word_q & ~c_w) | s_w;
    end else begin : g_clr_wins
      assign word_d = (word_q | s_w) & ~c_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else         word_q <= word_d;
    end

    assign bits_o[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/irq_ppr_calc.sv
module irq_ppr_calc
  import irq_prio_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_hi_i,
  output logic [VEC_W-1:0] ppr_o
);
  logic [CLASS_W-1:0] isr_cls;
  logic [CLASS_W-1:0] tpr_cls;

  assign isr_cls = isr_any_i ? isr_hi_i[VEC_W-1 -: CLASS_W] : '0;
  assign tpr_cls = tpr_i[VEC_W-1 -: CLASS_W];
  assign ppr_o   = (tpr_cls >= isr_cls) ? tpr_i
                                        : {isr_cls, {(VEC_W-CLASS_W){1'b0}}};
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_prio_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic             en_i,
  input  logic             req_any_i,
  input  logic [VEC_W-1:0] req_hi_i,
  input  logic [VEC_W-1:0] ppr_i,
  output logic             pending_o,
  output logic             masked_o
);
  assign pending_o = en_i & req_any_i;
  assign masked_o  = (ppr_i != '0) &&
                     (req_hi_i[VEC_W-1 -: CLASS_W] <= ppr_i[VEC_W-1 -: CLASS_W]);
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W,
  localparam int unsigned VEC_W     = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_valid_i,
  input  logic [VEC_W-1:0] set_vec_i,
  input  logic             set_level_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  input  logic             svr_we_i,
  input  logic [VEC_W:0]   svr_wdata_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             ack_valid_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic             eoi_bcast_o,
  output logic [VEC_W-1:0] eoi_vec_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] set_oh, irr_eff, ack_oh, eoi_oh;
  logic [NUM_VEC-1:0] tmr_set, tmr_clr;
  logic [VEC_W-1:0]   tpr_q;
  logic [VEC_W:0]     svr_q;
  logic               svr_en;

  logic               req_any, eff_any, isr_any;
  logic [VEC_W-1:0]   req_hi, eff_hi, isr_hi;
  logic               req_pend, req_masked, eff_pend, eff_masked;
  ack_kind_e          ack_kind;
  logic               eoi_take, eoi_level;

  logic               ack_valid_q, eoi_bcast_q;
  logic [VEC_W-1:0]   ack_vec_q, eoi_vec_q;

  assign svr_en  = svr_q[VEC_W];
  assign set_oh  = set_valid_i ? (NUM_VEC'(1) << set_vec_i) : '0;
  // set is applied ahead of a same-cycle acknowledge
  assign irr_eff = irr_q | set_oh;

  irq_prio_find #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_find_req (
    .bits_i(irr_q), .any_o(req_any), .idx_o(req_hi)
  );
  irq_prio_find #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_find_eff (
    .bits_i(irr_eff), .any_o(eff_any), .idx_o(eff_hi)
  );
  irq_prio_find #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_find_isr (
    .bits_i(isr_q), .any_o(isr_any), .idx_o(isr_hi)
  );

  irq_ppr_calc #(.VEC_W(VEC_W)) u_ppr (
    .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_hi_i(isr_hi), .ppr_o(ppr_o)
  );

  irq_gate #(.VEC_W(VEC_W)) u_gate_irq (
    .en_i(svr_en), .req_any_i(req_any), .req_hi_i(req_hi), .ppr_i(ppr_o),
    .pending_o(req_pend), .masked_o(req_masked)
  );
  irq_gate #(.VEC_W(VEC_W)) u_gate_ack (
    .en_i(svr_en), .req_any_i(eff_any), .req_hi_i(eff_hi), .ppr_i(ppr_o),
    .pending_o(eff_pend), .masked_o(eff_masked)
  );

  assign irq_o = req_pend & ~req_masked;

  always_comb begin
    ack_kind = ACK_NONE;
    if (ack_i && eff_pend) ack_kind = eff_masked ? ACK_SPUR : ACK_TAKE;
  end

  assign ack_oh    = (ack_kind == ACK_TAKE) ? (NUM_VEC'(1) << eff_hi) : '0;
  assign eoi_take  = eoi_i & isr_any;
  assign eoi_oh    = eoi_take ? (NUM_VEC'(1) << isr_hi) : '0;
  assign eoi_level = tmr_q[isr_hi];

  assign tmr_set = set_level_i ? set_oh : '0;
  assign tmr_clr = set_level_i ? '0 : set_oh;

  irq_vec_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SET_WINS(1'b0)) u_irr (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_mask_i(set_oh), .clr_mask_i(ack_oh),
    .bits_o(irr_q)
  );
  irq_vec_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SET_WINS(1'b1)) u_isr (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_mask_i(ack_oh), .clr_mask_i(eoi_oh),
    .bits_o(isr_q)
  );
  irq_vec_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SET_WINS(1'b1)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_mask_i(tmr_set), .clr_mask_i(tmr_clr),
    .bits_o(tmr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q <= '0;
      svr_q <= SVR_RST;
    end else begin
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
      if (svr_we_i) svr_q <= svr_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_q <= 1'b0;
      ack_vec_q   <= '0;
      eoi_bcast_q <= 1'b0;
      eoi_vec_q   <= '0;
    end else begin
      ack_valid_q <= (ack_kind != ACK_NONE);
      if (ack_kind == ACK_TAKE)      ack_vec_q <= eff_hi;
      else if (ack_kind == ACK_SPUR) ack_vec_q <= svr_q[VEC_W-1:0];
      eoi_bcast_q <= eoi_take & eoi_level;
      if (eoi_take & eoi_level) eoi_vec_q <= isr_hi;
    end
  end

  assign ack_valid_o = ack_valid_q;
  assign ack_vec_o   = ack_vec_q;
  assign eoi_bcast_o = eoi_bcast_q;
  assign eoi_vec_o   = eoi_vec_q;
endmodule

// File: rtl/irq_prio_unit_chk.sv
module irq_prio_unit_chk #(
  parameter int unsigned NUM_VEC = 256,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               set_valid_i,
  input logic [VEC_W-1:0]   set_vec_i,
  input logic               set_level_i,
  input logic               svr_we_i,
  input logic [VEC_W:0]     svr_wdata_i,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   ppr_o,
  input logic               ack_valid_o,
  input logic               eoi_bcast_o,
  input logic [VEC_W-1:0]   tpr_q,
  input logic [VEC_W:0]     svr_q,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q,
  input logic [NUM_VEC-1:0] tmr_q
);
  assert_ppr_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppr_o >= tpr_q) && ((ppr_o == tpr_q) || (ppr_o[3:0] == 4'h0)));

  assert_irq_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (svr_q[VEC_W] && (irr_q != '0)));

  assert_ack_follows_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(ack_i));

  assert_no_ack_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !svr_q[VEC_W]) |=> !ack_valid_o);

  assert_set_records_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_valid_i && !ack_i) |=>
      (irr_q[$past(set_vec_i)] && (tmr_q[$past(set_vec_i)] == $past(set_level_i))));

  assert_eoi_follows_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> $past(eoi_i));

  assert_eoi_empty_noop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && (isr_q == '0)) |=> !eoi_bcast_o);

  assert_svr_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svr_we_i |=> (svr_q == $past(svr_wdata_i)));
endmodule

bind irq_prio_unit irq_prio_unit_chk #(.NUM_VEC(NUM_VEC)) u_chk (.*);

// File: tb/irq_prio_unit_bench.sv
module irq_prio_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       set_valid_i = 1'b0;
  logic [7:0] set_vec_i = '0;
  logic       set_level_i = 1'b0;
  logic       tpr_we_i = 1'b0;
  logic [7:0] tpr_wdata_i = '0;
  logic       svr_we_i = 1'b0;
  logic [8:0] svr_wdata_i = '0;
  logic       ack_i = 1'b0;
  logic       eoi_i = 1'b0;
  logic       irq_o, ack_valid_o, eoi_bcast_o;
  logic [7:0] ppr_o, ack_vec_o, eoi_vec_o;

  irq_prio_unit u_irq_prio_unit (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  logic [7:0]   m_tpr = '0;
  logic [8:0]   m_svr = 9'h0FF;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hi_of(input logic [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] ppr_of(input logic [7:0] t, input logic [255:0] s);
    int h = hi_of(s);
    logic [3:0] c = (h < 0) ? 4'h0 : 4'(h >> 4);
    if (t[7:4] >= c) return t;
    return {c, 4'h0};
  endfunction

  function automatic bit masked_of(input int h, input logic [7:0] p);
    return (p != 8'h0) && (4'(h >> 4) <= p[7:4]);
  endfunction

  function automatic bit irq_exp();
    int h = hi_of(m_irr);
    return m_svr[8] && (h >= 0) && !masked_of(h, ppr_of(m_tpr, m_isr));
  endfunction

  task automatic step(input string ctx,
                      input bit s, input int sv, input bit sl,
                      input bit a, input bit e,
                      input bit tw, input int tv,
                      input bit sw, input int swv);
    logic [255:0] irr2, isr_clr, isr_set, tmr_old;
    logic [7:0]   p;
    bit exp_av, exp_eb;
    int exp_avec, exp_evec, h;
    @(negedge clk_i);
    set_valid_i = s; set_vec_i = 8'(sv); set_level_i = sl;
    ack_i = a; eoi_i = e;
    tpr_we_i = tw; tpr_wdata_i = 8'(tv);
    svr_we_i = sw; svr_wdata_i = 9'(swv);
    // model: set, then acknowledge, then EOI against pre-edge state
    tmr_old = m_tmr;
    irr2 = m_irr;
    if (s) begin
      irr2[sv] = 1'b1;
      m_tmr[sv] = sl;
    end
    p = ppr_of(m_tpr, m_isr);
    exp_av = 1'b0; exp_avec = -1; isr_set = '0; isr_clr = '0;
    h = hi_of(irr2);
    if (a && m_svr[8] && h >= 0) begin
      exp_av = 1'b1;
      if (masked_of(h, p)) exp_avec = m_svr[7:0];
      else begin
        exp_avec = h; irr2[h] = 1'b0; isr_set[h] = 1'b1;
      end
    end
    exp_eb = 1'b0; exp_evec = -1;
    h = hi_of(m_isr);
    if (e && h >= 0) begin
      isr_clr[h] = 1'b1;
      if (tmr_old[h]) begin exp_eb = 1'b1; exp_evec = h; end
    end
    m_irr = irr2;
    m_isr = (m_isr & ~isr_clr) | isr_set;
    if (tw) m_tpr = 8'(tv);
    if (sw) m_svr = 9'(swv);
    @(posedge clk_i);
    #1;
    chk($sformatf("R6 ack_valid %s", ctx), int'(ack_valid_o), int'(exp_av));
    if (exp_av) chk($sformatf("R7 ack_vec %s", ctx), int'(ack_vec_o), exp_avec);
    chk($sformatf("R9 eoi_bcast %s", ctx), int'(eoi_bcast_o), int'(exp_eb));
    if (exp_eb) chk($sformatf("R9 eoi_vec %s", ctx), int'(eoi_vec_o), exp_evec);
    chk($sformatf("R5 irq %s", ctx), int'(irq_o), int'(irq_exp()));
    chk($sformatf("R3 ppr %s", ctx), int'(ppr_o), int'(ppr_of(m_tpr, m_isr)));
  endtask

  task automatic idle(input string ctx);
    step(ctx, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1;
    // R12: reset state
    chk("R12 irq", int'(irq_o), 0);
    chk("R12 ppr", int'(ppr_o), 0);
    chk("R12 ack_valid", int'(ack_valid_o), 0);
    chk("R12 eoi_bcast", int'(eoi_bcast_o), 0);
    rst_ni = 1'b1;
    idle("R12 post-reset");

    // R4: disabled unit holds irq low; R7: no ack result while disabled
    step("R4 set-disabled", 1, 8'h45, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 irq disabled", int'(irq_o), 0);
    step("R7 ack-disabled", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R7 no result", int'(ack_valid_o), 0);
    // R10: enable with spurious 0xAB
    step("R10 svr write", 0, 0, 0, 0, 0, 0, 0, 1, 9'h1AB);
    chk("R10 irq after enable", int'(irq_o), 1);
    // R5: task priority class 5 masks class 4
    step("R5 tpr 0x50", 0, 0, 0, 0, 0, 1, 8'h50, 0, 0);
    chk("R5 masked", int'(irq_o), 0);
    chk("R10 ppr tracks tpr", int'(ppr_o), 8'h50);
    step("R7 spurious", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R7 spurious vec", int'(ack_vec_o), 8'hAB);
    step("R7 unmask", 0, 0, 0, 0, 0, 1, 8'h00, 0, 0);
    chk("R7 request kept", int'(irq_o), 1);
    step("R6 take 0x45", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 vec", int'(ack_vec_o), 8'h45);
    chk("R3 ppr from isr", int'(ppr_o), 8'h40);
    // R2/R1: highest wins across words, level vs edge
    step("R8 set ff level", 1, 8'hFF, 1, 0, 0, 0, 0, 0, 0);
    step("R8 set 00 edge", 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    step("R2 take ff", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R2 highest", int'(ack_vec_o), 8'hFF);
    chk("R3 ppr f0", int'(ppr_o), 8'hF0);
    step("R9 eoi level", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9 bcast ff", int'(eoi_bcast_o), 1);
    chk("R9 bcast vec", int'(eoi_vec_o), 8'hFF);
    step("R9 eoi edge", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9 edge no bcast", int'(eoi_bcast_o), 0);
    step("R9 eoi empty", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9 empty no bcast", int'(eoi_bcast_o), 0);
    step("R1 drain 00", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R1 eoi 00", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R1: word boundary 31/32
    step("R1 set 1f", 1, 8'h1F, 1, 0, 0, 0, 0, 0, 0);
    step("R1 set 20", 1, 8'h20, 0, 0, 0, 0, 0, 0, 0);
    step("R1 take 20", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R1 vec 20", int'(ack_vec_o), 8'h20);
    step("R1 eoi 20", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R1 edge 20 no bcast", int'(eoi_bcast_o), 0);
    step("R1 take 1f", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R1 vec 1f", int'(ack_vec_o), 8'h1F);
    step("R1 eoi 1f", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R1 level 1f bcast", int'(eoi_bcast_o), 1);
    // R8: edge set overrides earlier level
    step("R8 set 90 level", 1, 8'h90, 1, 0, 0, 0, 0, 0, 0);
    step("R8 set 90 edge", 1, 8'h90, 0, 0, 0, 0, 0, 0, 0);
    step("R8 take 90", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R8 eoi 90", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R8 edge cleared trigger", int'(eoi_bcast_o), 0);
    // R11: set and acknowledge together
    step("R11 set+ack", 1, 8'h80, 0, 1, 0, 0, 0, 0, 0);
    chk("R11 vec 80", int'(ack_vec_o), 8'h80);
    step("R11 eoi", 0, 0, 0, 0, 1, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit s  = ($urandom % 3) == 0;
      int sv = (($urandom % 4) == 0) ? int'($urandom % 256)
                                     : int'({4'($urandom % 16), 4'h0} | ($urandom % 3));
      bit sl = $urandom % 2;
      bit a  = ($urandom % 4) == 0;
      bit e  = ($urandom % 5) == 0;
      bit tw = ($urandom % 25) == 0;
      int tv = $urandom % 256;
      bit sw = ($urandom % 60) == 0;
      int swv = (($urandom % 6) == 0 ? 0 : 256) | int'($urandom % 256);
      step("random", s, sv, sl, a, e, tw, tv, sw, swv);
    end
    idle("final");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule